// File: doc/BRIEF.md
# Two-Wire Slave with Indirect Fuse Column Readback

This block is a two-wire serial bus slave that runs entirely in a fast system clock domain. It oversamples the clock and data lines through a short synchronizer, finds the bus framing events, and serves a small register space. That space is reached through a byte pointer. The data line is driven open-drain: the block only ever pulls it low, and an external pull-up supplies the high level.

One bit of the 7-bit device address comes from a strap input. This lets two copies share a bus. The register space holds general scratch registers, a fuse column index register and a fuse readback register. A read of the readback register returns the word stored in the fuse column that the index register selects. That word comes from a read-only fuse array modelled beside the register bank. To read a column, the host writes the index and then reads the readback register. Repeating that pair walks through the other columns.

Top module: `i2c_fuse_slave`

## Requirements
- R1: The device answers to the 7-bit address {1,1,0,0,0,addr_strap,0}, which gives address bytes 0xC0 (write) and 0xC1 (read) with the strap low, and 0xC4 and 0xC5 with the strap high. On a match it holds SDA low for the whole high phase of the ninth clock. On a mismatch it leaves SDA released during that clock and for the rest of the transfer.
- R2: A START (SDA falling while SCL is high) in any state, including partway through a byte, restarts reception of an address byte from its first bit. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: In a write transfer, the first data byte after the address sets the register pointer from its low three bits. The slave acknowledges every data byte by holding SDA low during the ninth clock.
- R4: Each later data byte of a write is stored at the pointer, and the pointer then advances by one. The pointer wraps from 7 to 0.
- R5: A read transfer returns bytes MSB first, starting at the current pointer and advancing it after each byte. Every SDA level the slave drives stays constant while SCL is high. The slave releases SDA during the ninth clock so that the master can acknowledge.
- R6: After the master answers a read byte with a NACK, the slave drives nothing more until the next START or STOP, whatever further clocks arrive.
- R7: Register 6 is the fuse column index and register 7 is the fuse readback register. A read of register 7 returns the word of column (index mod 16). The word of column c is ((c*29) mod 256) XOR 0xA5.
- R8: A write to register 7 is acknowledged and changes no register. The pointer still advances.
- R9: After reset, SDA is released, all registers read 0 and the pointer is 0.
- R10: The slave never pulls SDA low while the master is sending address or data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_strap | input | 1 | Strap that sets address bit 1 |
| sda_oe_n | output | 1 | Active-low pull-down enable for SDA (1 = released) |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except at START and STOP, and every SCL phase lasts several system clocks, so the synchronized edges arrive in order and never merge. The bench master drives SCL with low and high phases of a dozen or more system clocks. It moves SDA two cycles after SCL falls and checks the slave's drive only inside the stable SCL-high window. Its master never starts a transfer while the slave holds SDA low. The mid-byte restart case still obeys these rules, because the repeated START is issued from an SCL-low phase.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } fsl_state_e;

  // Content of one fuse column, a fixed function of its index.
  function automatic logic [BYTE_W-1:0] fuse_word(input int unsigned col);
    logic [BYTE_W-1:0] prod;
    prod = BYTE_W'(col * 29);
    return prod ^ 8'hA5;
  endfunction

endpackage

// File: rtl/fsl_line_sampler.sv
module fsl_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now_v;
  logic [LINES-1:0] prev_v;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [SYNC_STAGES-1:0] sh;
    logic                   last;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '1;
        last <= 1'b1;
      end else begin
        sh   <= {sh[SYNC_STAGES-2:0], raw[l]};
        last <= sh[SYNC_STAGES-1];
      end
    end
    assign now_v[l]  = sh[SYNC_STAGES-1];
    assign prev_v[l] = last;
  end

  logic scl_d, sda_d;
  assign scl_s = now_v[1];
  assign sda_s = now_v[0];
  assign scl_d = prev_v[1];
  assign sda_d = prev_v[0];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/fsl_fuse_rom.sv
module fsl_fuse_rom
  import fsl_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic              clk,
  input  logic [COL_W-1:0]  col,
  output logic [BYTE_W-1:0] data
);

  localparam int COLS = 1 << COL_W;

  logic [BYTE_W-1:0] rom [COLS];

  always_comb begin
    for (int c = 0; c < COLS; c++) rom[c] = fuse_word(unsigned'(c));
  end

  // Registered read port, suited to a block ROM.
  always_ff @(posedge clk) data <= rom[col];

endmodule

// File: rtl/fsl_reg_bank.sv
module fsl_reg_bank
  import fsl_pkg::*;
#(
  parameter int PTR_W = 3,
  parameter int COL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  input  logic [BYTE_W-1:0] fuse_data,
  output logic [BYTE_W-1:0] rdata,
  output logic [COL_W-1:0]  fuse_col
);

  localparam int              NREG     = 1 << PTR_W;
  localparam logic [PTR_W-1:0] DAT_SLOT = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] IDX_SLOT = DAT_SLOT - 1'b1;

  logic [BYTE_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != DAT_SLOT) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata    = (raddr == DAT_SLOT) ? fuse_data : regs[raddr];
  assign fuse_col = regs[IDX_SLOT][COL_W-1:0];

  // R8: the protocol engine never issues a store to the readback slot
  assert_no_readback_write_R8: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != DAT_SLOT));

endmodule

// File: rtl/fsl_proto.sv
module fsl_proto
  import fsl_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_strap,
  input  logic [BYTE_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic              we,
  output logic [PTR_W-1:0]  waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              drive_low
);

  localparam logic [PTR_W-1:0] DAT_SLOT = {PTR_W{1'b1}};
  localparam logic [3:0]       LAST_BIT = 4'd8;

  fsl_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              is_read;
  logic              ptr_phase;
  logic              mack_ok;
  logic [6:0]        my_addr;

  assign my_addr = {5'b11000, addr_strap, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      is_read   <= 1'b0;
      ptr_phase <= 1'b0;
      mack_ok   <= 1'b0;
      drive_low <= 1'b0;
      ptr       <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        bit_cnt   <= '0;
        drive_low <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
              rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (rx_sh[7:1] == my_addr) begin
                  drive_low <= 1'b1;
                  is_read   <= rx_sh[0];
                  ptr_phase <= 1'b1;
                  state     <= ST_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                drive_low <= 1'b1;
                is_read   <= 1'b0;
                state     <= ST_ACK;
                if (ptr_phase) begin
                  ptr       <= rx_sh[PTR_W-1:0];
                  ptr_phase <= 1'b0;
                end else begin
                  if (ptr != DAT_SLOT) begin
                    we    <= 1'b1;
                    waddr <= ptr;
                    wdata <= rx_sh;
                  end
                  ptr <= ptr + 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sh     <= rdata;
                drive_low <= ~rdata[7];
                state     <= ST_TX;
              end else begin
                drive_low <= 1'b0;
                state     <= ST_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                drive_low <= 1'b0;
                ptr       <= ptr + 1'b1;
                state     <= ST_MACK;
              end else begin
                drive_low <= ~tx_sh[6];
                tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_s;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (mack_ok) begin
                tx_sh     <= rdata;
                drive_low <= ~rdata[7];
                state     <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a START from any state restarts address reception
  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_ADDR && bit_cnt == 4'd0 && !drive_low));

  // R2: a STOP returns to idle with the line released
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !drive_low));

  // R10: pull-down only in the slave's own acknowledge or transmit phases
  assert_drive_states_R10: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> (state == ST_ACK || state == ST_TX));

  // R5: the driven level does not move while SCL is high
  assert_sda_stable_hi_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(drive_low));

  // R6: the waiting state is left only through START or STOP
  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_WAIT) && !$past(start_det) && !$past(stop_det))
      |-> (state == ST_WAIT && !drive_low));

endmodule

// File: rtl/i2c_fuse_slave.sv
module i2c_fuse_slave
  import fsl_pkg::*;
#(
  parameter int PTR_W       = 3,
  parameter int FUSE_COL_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_strap,
  output logic sda_oe_n
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0]      ptr;
  logic                  we;
  logic [PTR_W-1:0]      waddr;
  logic [BYTE_W-1:0]     wdata;
  logic [BYTE_W-1:0]     rdata;
  logic [BYTE_W-1:0]     fuse_data;
  logic [FUSE_COL_W-1:0] fuse_col;
  logic                  drive_low;

  fsl_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  fsl_proto #(.PTR_W(PTR_W)) u_proto (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_strap(addr_strap), .rdata(rdata), .ptr(ptr),
    .we(we), .waddr(waddr), .wdata(wdata), .drive_low(drive_low)
  );

  fsl_reg_bank #(.PTR_W(PTR_W), .COL_W(FUSE_COL_W)) u_regs (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .fuse_data(fuse_data), .rdata(rdata), .fuse_col(fuse_col)
  );

  fsl_fuse_rom #(.COL_W(FUSE_COL_W)) u_fuse (
    .clk(clk), .col(fuse_col), .data(fuse_data)
  );

  assign sda_oe_n = ~drive_low;

endmodule

// File: tb/i2c_fuse_slave_tb.sv
module i2c_fuse_slave_tb;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe_n;
  wire  sda_line = sda_m & sda_oe_n;

  always #5 clk = ~clk;

  i2c_fuse_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_oe_n(sda_oe_n)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    win      = 1'b0;
  int    exp_drv  = 0;    // 0 released, 1 pulled low, 2 no check
  string win_tag  = "";

  logic [7:0] mdl_regs [8];
  int         mdl_ptr = 0;

  function automatic logic [7:0] fuse_ref(input int c);
    logic [7:0] p;
    p = 8'(c * 29);
    return p ^ 8'hA5;
  endfunction

  // Per-clock comparison against the reference expectation
  always @(negedge clk) begin
    if (win && exp_drv != 2) begin
      logic e;
      e = (exp_drv == 1) ? 1'b0 : 1'b1;
      n_checks++;
      if (sda_oe_n !== e) begin
        n_fail++;
        $display("FAIL %s: sda_oe_n=%0b expected %0b", win_tag, sda_oe_n, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, input int e, input string tag);
    sda_m = b;
    wait_cyc(Q);
    scl_m = 1'b1;
    wait_cyc(1);
    win_tag = tag; exp_drv = e; win = 1'b1;
    wait_cyc(2*Q - 2);
    win = 1'b0;
    wait_cyc(1);
    scl_m = 1'b0;
    wait_cyc(2);
  endtask

  task automatic start_cond();
    if (scl_m == 1'b0) begin
      sda_m = 1'b1; wait_cyc(Q);
      scl_m = 1'b1; wait_cyc(Q);
    end
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(2);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b1; wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input int ack_e, input string tag);
    for (int i = 7; i >= 0; i--) bus_bit(v[i], 0, {"R10 ", tag, " bit"});
    bus_bit(1'b1, ack_e, {tag, " ack"});
  endtask

  task automatic recv_byte(input logic [7:0] ev, input bit m_ack, input string tag);
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, ev[i] ? 0 : 1, tag);
    bus_bit(m_ack ? 1'b0 : 1'b1, 0, {"R5 ", tag, " master-ack slot"});
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] bytes[$], input string tag);
    start_cond();
    send_byte({a, 1'b0}, 1, {"R1 ", tag, " addr"});
    foreach (bytes[k]) begin
      if (k == 0) mdl_ptr = int'(bytes[k][2:0]);
      else begin
        if (mdl_ptr != 7) mdl_regs[mdl_ptr] = bytes[k];
        mdl_ptr = (mdl_ptr + 1) % 8;
      end
      send_byte(bytes[k], 1, (k == 0) ? {"R3 ", tag} : {"R4 ", tag});
    end
    stop_cond();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input int extra, input string tag);
    start_cond();
    send_byte({a, 1'b1}, 1, {"R1 ", tag, " addr"});
    for (int k = 0; k < n; k++) begin
      logic [7:0] ev;
      ev = (mdl_ptr == 7) ? fuse_ref(int'(mdl_regs[6][3:0])) : mdl_regs[mdl_ptr];
      recv_byte(ev, k < n - 1, $sformatf("%s byte%0d exp %02h", tag, k, ev));
      mdl_ptr = (mdl_ptr + 1) % 8;
    end
    for (int x = 0; x < extra; x++) send_byte(8'h00, 0, "R6 clocks after master NACK");
    stop_cond();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl_regs[i] = 8'h00;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    n_checks++;
    if (sda_oe_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 reset: sda_oe_n=%0b expected 1", sda_oe_n);
    end

    // R9: registers read zero from pointer 0 after reset
    do_read(7'h60, 3, 0, "R9 reset contents");

    // R3 R4 R5: pointer set, sequential writes, sequential read
    do_write(7'h60, '{8'h01, 8'h11, 8'h22, 8'h33}, "seq write");
    do_write(7'h60, '{8'h01}, "set ptr");
    do_read(7'h60, 3, 0, "R5 seq read");

    // R4 R7 R8: wrap through index and readback slots
    do_write(7'h60, '{8'h04, 8'hA1, 8'hB2, 8'h03, 8'hFF, 8'hC4}, "wrap write");
    do_write(7'h60, '{8'h06}, "set ptr 6");
    do_read(7'h60, 3, 0, "R7 R4 idx fuse wrap");
    do_write(7'h60, '{8'h04}, "set ptr 4");
    do_read(7'h60, 4, 0, "R8 readback write ignored");

    // R7: index taken modulo the column count
    do_write(7'h60, '{8'h06, 8'h1D}, "fuse idx 1D");
    do_read(7'h60, 2, 0, "R7 fuse col 13");
    do_write(7'h60, '{8'h06, 8'h0A}, "fuse idx 0A");
    do_read(7'h60, 2, 0, "R7 fuse col 10");

    // R1: address mismatch with strap low
    start_cond();
    send_byte({7'h62, 1'b1}, 0, "R1 mismatch strap0 addr");
    send_byte(8'h00, 0, "R1 after mismatch");
    stop_cond();

    // R1: strap high moves the address
    strap = 1'b1;
    wait_cyc(4);
    do_write(7'h62, '{8'h00, 8'h5C}, "strap1 write");
    do_write(7'h62, '{8'h00}, "strap1 ptr");
    do_read(7'h62, 1, 0, "R1 strap1 read");
    start_cond();
    send_byte({7'h60, 1'b0}, 0, "R1 mismatch strap1 addr");
    stop_cond();

    // R6: NACK then further clocks stay released
    do_write(7'h62, '{8'h01}, "ptr for nack");
    do_read(7'h62, 2, 2, "R6 nack read");

    // R2: repeated START partway through a byte restarts the address
    start_cond();
    bus_bit(1'b1, 0, "R2 partial bit");
    bus_bit(1'b0, 0, "R2 partial bit");
    bus_bit(1'b1, 0, "R2 partial bit");
    start_cond();
    send_byte({7'h62, 1'b0}, 1, "R2 addr after restart");
    send_byte(8'h02, 1, "R2 ptr after restart");
    mdl_ptr = 2;
    stop_cond();
    do_read(7'h62, 2, 0, "R2 read after restart");

    wait_cyc(10);
    finish_run();
  end

endmodule